// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block sits between eight interrupt request lines and a processor. A rising edge on any request line sets a pending bit, and that bit stays set until the processor accepts the request. Each line has its own enable bit. Arbitration picks the most important pending line that is enabled. The single interrupt output is raised only when that line outranks every routine already being serviced. Because the block tracks which routines are in service, a more important request can interrupt a less important routine that is still running.

The processor accepts an interrupt by pulsing an acknowledge input while the interrupt output is high. In that cycle the block presents a vector number, equal to a programmable base plus the line index, and moves the line from pending to in service. Software ends a routine by issuing an end-of-interrupt command through a small register-write port. The same port also programs the enable mask, the vector base and the priority mode.

In fixed mode, line 0 ranks highest and line 7 lowest. In rotating mode, the line whose routine has just ended drops to the bottom of the order, so lines of equal importance take turns.

The controller has three named states:
- **ST_IDLE**: nothing is in service and no request is eligible.
- **ST_RAISE**: the interrupt output is high.
- **ST_SERVE**: at least one routine is in service and no request may nest.

Its transitions are:
- **go_raise**: ST_IDLE or ST_SERVE to ST_RAISE, taken when a request becomes eligible.
- **accept**: ST_RAISE to ST_SERVE, taken on acknowledge.
- **withdraw**: ST_RAISE to ST_IDLE or ST_SERVE, taken when the request is no longer eligible.
- **drain**: ST_SERVE to ST_IDLE, taken when the last routine ends and nothing is eligible.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A rising edge on `req_i[i]` sets pending bit i. The bit stays set until that line is acknowledged, however long it loses arbitration or stays masked.
- R2: A line whose mask bit is 1 never raises `irq_o`. Once it is unmasked, its held pending request can win.
- R3: In fixed mode, line 0 has the highest priority and line 7 the lowest.
- R4: `irq_o` stays low while the best eligible line ranks equal to or below the highest in-service line.
- R5: A pending, unmasked line that outranks every in-service line raises `irq_o`, so routines nest.
- R6: While `irq_o` is high, `vec_o` equals the vector base plus the 3-bit index of the selected line; while `irq_o` is low, `vec_o` is 0. An `ack_i` during `irq_o` moves that line from pending to in service at the clock edge.
- R7: If a new rising edge on a line arrives in the same cycle as the acknowledge of that line, the pending bit remains set.
- R8: An end-of-interrupt command clears only the highest-priority in-service bit under the current order. With nothing in service it has no effect.
- R9: In rotating mode, after an end-of-interrupt clears line i, line i becomes the lowest priority and line (i+1) mod 8 the highest.
- R10: Writes with `wr_en_i` high decode `wr_sel_i` as follows: 0 loads the mask from `wr_data_i`, 1 loads the vector base, 2 loads the mode from bit 0 (1 means rotating), and 3 is an end-of-interrupt command. Switching back to fixed mode restores the order 0 to 7 whatever rotation has taken place.
- R11: After reset, `irq_o` and `vec_o` are 0. Nothing is pending or in service, all lines are unmasked, the base is 0 and the mode is fixed.
- R12: `irq_o` is registered. It rises the clock after the pending state makes a line eligible, and it is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Request lines, edge sensitive |
| ack_i | input | 1 | Processor acknowledge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 base, 2 mode, 3 end of interrupt |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number, valid while irq_o is high |

## Verification
The hardest situation to reach from the ports is one where several routines are nested and the order has been rotated. In that situation the end-of-interrupt command must clear the right in-service bit, and that bit is invisible from outside. The stimulus stacks two routines in service and then ends one of them. It then raises a line that ranks between the two: the interrupt line rises only if the more important routine was the one cleared. Rotation is reached by ending specific routines in rotating mode and then offering two lines at once, whose winner differs from the fixed order. A request edge coinciding with its own acknowledge is produced by driving both on the same cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAISE = 2'd1,
        ST_SERVE = 2'd2
    } nic_state_e;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_BASE = 2'd1,
        SEL_MODE = 2'd2,
        SEL_EOI  = 2'd3
    } nic_sel_e;

endpackage

// File: rtl/nic_edge_latch.sv
module nic_edge_latch #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] req_q;
    logic [N-1:0] rise;
    logic [N-1:0] pend_q;

    assign rise = req_i & ~req_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_i;
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    assign pend_o = pend_q;

    // R1: a pending bit that is not cleared survives the edge
    p_hold_pending_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

    // R7: a fresh edge always leaves the bit set, even when it is cleared
    p_edge_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

endmodule

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    input  logic [IDX_W-1:0] low_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] rank_o
);

    always_comb begin
        int pos;
        found_o = 1'b0;
        idx_o   = '0;
        rank_o  = '0;
        pos     = 0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = (int'(low_i) + 1 + k) % N;
            if (vec_i[pos]) begin
                found_o = 1'b1;
                idx_o   = pos[IDX_W-1:0];
                rank_o  = k[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/nic_isr_track.sv
module nic_isr_track #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_en_i,
    input  logic [IDX_W-1:0] set_idx_i,
    input  logic             eoi_i,
    input  logic             top_found_i,
    input  logic [IDX_W-1:0] top_idx_i,
    input  logic             rotate_i,
    output logic [N-1:0]     isr_o,
    output logic [IDX_W-1:0] low_o
);

    logic [N-1:0]     isr_q;
    logic [N-1:0]     set_vec;
    logic [N-1:0]     clr_vec;
    logic [IDX_W-1:0] low_q;
    logic             do_clear;

    assign do_clear = eoi_i && top_found_i;
    assign set_vec  = set_en_i ? (N'(1) << set_idx_i) : '0;
    assign clr_vec  = do_clear ? (N'(1) << top_idx_i) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            isr_q <= '0;
            low_q <= IDX_W'(N - 1);
        end else begin
            isr_q <= (isr_q & ~clr_vec) | set_vec;
            if (do_clear && rotate_i) begin
                low_q <= top_idx_i;
            end
        end
    end

    assign isr_o = isr_q;
    assign low_o = low_q;

    // R6: an accepted line is in service on the next cycle
    p_set_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i |=> isr_q[$past(set_idx_i)]);

    // R8: an end-of-interrupt removes exactly one routine
    p_eoi_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (do_clear && !set_en_i) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

    // R8: an end-of-interrupt with nothing in service changes nothing
    p_eoi_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_i && (isr_q == '0) && !set_en_i) |=> (isr_q == '0));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    parameter int IDX_W = $clog2(N),
    parameter int DW    = (N > VEC_W) ? N : VEC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N-1:0]     req_i,
    input  logic             ack_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    import nic_pkg::*;

    nic_state_e       state_q, state_d;
    logic [N-1:0]     mask_q;
    logic [VEC_W-1:0] base_q;
    logic             rot_q;
    logic [IDX_W-1:0] win_q;

    logic [N-1:0]     pend;
    logic [N-1:0]     cand;
    logic [N-1:0]     isr;
    logic [N-1:0]     clr_pend;
    logic [IDX_W-1:0] low_ptr;
    logic [IDX_W-1:0] eff_low;
    logic             c_found, s_found;
    logic [IDX_W-1:0] c_idx, c_rank, s_idx, s_rank;
    logic             eligible;
    logic             take;
    logic             eoi;

    assign eff_low  = rot_q ? low_ptr : IDX_W'(N - 1);
    assign cand     = pend & ~mask_q;
    assign take     = ack_i && (state_q == ST_RAISE);
    assign clr_pend = take ? (N'(1) << win_q) : '0;
    assign eoi      = wr_en_i && (wr_sel_i == SEL_EOI);
    assign eligible = c_found && (!s_found || (c_rank < s_rank));

    nic_edge_latch #(.N(N)) u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .clr_i  (clr_pend),
        .pend_o (pend)
    );

    nic_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_req (
        .vec_i   (cand),
        .low_i   (eff_low),
        .found_o (c_found),
        .idx_o   (c_idx),
        .rank_o  (c_rank)
    );

    nic_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_isr (
        .vec_i   (isr),
        .low_i   (eff_low),
        .found_o (s_found),
        .idx_o   (s_idx),
        .rank_o  (s_rank)
    );

    nic_isr_track #(.N(N), .IDX_W(IDX_W)) u_isr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_en_i    (take),
        .set_idx_i   (win_q),
        .eoi_i       (eoi),
        .top_found_i (s_found),
        .top_idx_i   (s_idx),
        .rotate_i    (rot_q),
        .isr_o       (isr),
        .low_o       (low_ptr)
    );

    // configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
            base_q <= '0;
            rot_q  <= 1'b0;
        end else if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_MASK: mask_q <= wr_data_i[N-1:0];
                SEL_BASE: base_q <= wr_data_i[VEC_W-1:0];
                SEL_MODE: rot_q  <= wr_data_i[0];
                default:  ;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eligible) state_d = ST_RAISE;             // go_raise
            end
            ST_RAISE: begin
                if (take)           state_d = ST_SERVE;       // accept
                else if (!eligible) state_d = s_found ? ST_SERVE : ST_IDLE; // withdraw
            end
            ST_SERVE: begin
                if (eligible)      state_d = ST_RAISE;        // go_raise
                else if (!s_found) state_d = ST_IDLE;         // drain
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // latched winner presented with the interrupt
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  win_q <= '0;
        else if (state_d == ST_RAISE) win_q <= c_idx;
    end

    // outputs
    always_comb begin
        irq_o = (state_q == ST_RAISE);
        vec_o = irq_o ? (base_q + VEC_W'(win_q)) : '0;
    end

    // R12: the interrupt line drops after an acknowledge
    p_drop_after_ack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> !irq_o);

    // R2: the presented line was unmasked when it was chosen
    p_masked_never_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (($past(mask_q) & (N'(1) << win_q)) == '0));

    // R4: the presented line is never one already in service
    p_not_in_service_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((isr & (N'(1) << win_q)) == '0));

    // R6: the vector is zero whenever the interrupt line is low
    p_vec_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (vec_o == '0));

endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req;
    logic       ack;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       irq_o;
    logic [7:0] vec_o;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    nest_irq_ctrl dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .req_i     (req),
        .ack_i     (ack),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .irq_o     (irq_o),
        .vec_o     (vec_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(logic [7:0] m);
        req = req | m;
        step();
        req = req & ~m;
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic expect_irq(string tag, logic [7:0] v);
        chk({tag, " irq"}, irq_o, 1'b1);
        chk({tag, " vec"}, vec_o, v);
    endtask

    task automatic expect_quiet(string tag);
        chk({tag, " irq low"}, irq_o, 1'b0);
    endtask

    task automatic do_ack(logic [7:0] v);
        chk("R6 irq before ack", irq_o, 1'b1);
        exp_q.push_back(v);
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk("R12 irq low after ack", irq_o, 1'b0);
    endtask

    // scoreboard monitor: compares vectors seen during an acknowledge
    always begin
        @(negedge clk);
        #2;
        if (ack && irq_o) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R6 scoreboard: actual %0h expected none", vec_o);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec_o !== e) begin
                    n_err++;
                    $display("FAIL R6 scoreboard: actual %0h expected %0h", vec_o, e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; ack = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R11 reset irq", irq_o, 1'b0);
        chk("R11 reset vec", vec_o, 8'h00);

        // R10 base write, R3 fixed order
        wr(2'd1, 8'h40);
        pulse(8'h24);
        step();
        expect_irq("R3 line 2 beats 5", 8'h42);
        do_ack(8'h42);
        step(); step();
        expect_quiet("R4 lower pending blocked");
        pulse(8'h04);
        step(); step();
        expect_quiet("R4 equal pending blocked");
        wr(2'd3, 8'h00);
        step();
        expect_irq("R8 eoi frees line 2", 8'h42);
        do_ack(8'h42);
        wr(2'd3, 8'h00);
        step();
        expect_irq("R3 line 5 next", 8'h45);
        do_ack(8'h45);

        // R5 nesting, R8 clears the higher routine only
        pulse(8'h02);
        step();
        expect_irq("R5 line 1 nests over 5", 8'h41);
        do_ack(8'h41);
        wr(2'd3, 8'h00);
        step(); step();
        expect_quiet("R8 nothing pending");
        pulse(8'h08);
        step();
        expect_irq("R8 line 3 outranks remaining 5", 8'h43);
        do_ack(8'h43);
        wr(2'd3, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd3, 8'h00);
        pulse(8'h80);
        step();
        expect_irq("R8 empty eoi harmless", 8'h47);
        do_ack(8'h47);
        wr(2'd3, 8'h00);

        // R2 mask, R1 held pending
        wr(2'd0, 8'h10);
        pulse(8'h10);
        step(); step(); step();
        expect_quiet("R2 masked line");
        wr(2'd0, 8'h00);
        step();
        expect_irq("R1 held request after unmask", 8'h44);
        do_ack(8'h44);
        wr(2'd3, 8'h00);

        // R7 edge coinciding with acknowledge
        pulse(8'h40);
        step();
        expect_irq("R7 line 6 first", 8'h46);
        chk("R7 irq before ack", irq_o, 1'b1);
        exp_q.push_back(8'h46);
        ack = 1'b1; req[6] = 1'b1;
        step();
        ack = 1'b0; req[6] = 1'b0;
        chk("R7 irq low after ack", irq_o, 1'b0);
        wr(2'd3, 8'h00);
        step();
        expect_irq("R7 pending kept", 8'h46);
        do_ack(8'h46);
        wr(2'd3, 8'h00);

        // R9 rotating mode
        wr(2'd2, 8'h01);
        pulse(8'h08);
        step();
        expect_irq("R9 line 3", 8'h43);
        do_ack(8'h43);
        wr(2'd3, 8'h00);
        pulse(8'h14);
        step();
        expect_irq("R9 line 4 beats 2 after rotation", 8'h44);
        do_ack(8'h44);
        step(); step();
        expect_quiet("R4 rotating blocked");
        wr(2'd3, 8'h00);
        step();
        expect_irq("R9 line 2 after 4 ends", 8'h42);
        do_ack(8'h42);
        wr(2'd3, 8'h00);
        pulse(8'h0C);
        step();
        expect_irq("R9 line 3 highest after 2", 8'h43);
        do_ack(8'h43);
        wr(2'd3, 8'h00);
        step();
        expect_irq("R9 line 2 last", 8'h42);
        do_ack(8'h42);
        wr(2'd3, 8'h00);

        // R10 back to fixed order
        wr(2'd2, 8'h00);
        pulse(8'h84);
        step();
        expect_irq("R10 fixed order restored", 8'h42);
        do_ack(8'h42);
        wr(2'd3, 8'h00);
        step();
        expect_irq("R10 line 7 after 2", 8'h47);
        do_ack(8'h47);
        wr(2'd3, 8'h00);

        step(); step();
        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule